// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The combiner takes a wide bank of level-sensitive interrupt lines, splits it into groups of eight, and drives one output per group. A group output is high while at least one of its sources is both asserted and enabled. Software controls the per-source enables through write-one-to-set and write-one-to-clear words, and reads raw and masked state through status words. A per-group summary region reports which groups are firing.

Registers are 32-bit words on a simple single-cycle access port. Each group of four consecutive words serves four neighbouring groups, and each word carries one byte per group. A strap input selects a reduced variant that accepts only the lower groups and a narrow address window. Accesses the block does not accept raise a one-cycle error pulse and change nothing.

Top module: `irq_comb`

## Requirements
- R1: Input n belongs to group n/8 at bit n%8; output g is high exactly when the 8-bit enable mask of group g ANDed with its 8-bit pending vector is nonzero.
- R2: A change of input level, or a mask write, shows on the group outputs and in the status words at the first rising clock edge after it is presented, not before.
- R3: Pending bits follow the input levels with no latching: an input that goes low clears its pending bit and removes its contribution to the output.
- R4: The word at byte offset 16q+0 is enable-set: a 1 in bit 8k+b ORs bit b into the mask of group 4q+k; zero bits leave the mask untouched.
- R5: The word at byte offset 16q+4 is enable-clear: a 1 in bit 8k+b clears bit b of the mask of group 4q+k; zero bits leave the mask untouched.
- R6: Reading offset 16q+8 returns the raw pending bytes of groups 4q..4q+3 (group 4q+k in bits 8k+7..8k); offset 16q+12 returns pending AND mask in the same layout; reads of offsets 16q+0 and 16q+4 return zero.
- R7: Summary words start at byte offset 4*NUM_GROUPS (0x100 by default), one word per 32 groups; bit g%32 of word g/32 equals output g; the words are read-only.
- R8: Writes to offsets 16q+8 or 16q+12, writes to summary words, and any access past the last summary word are illegal: the cycle after, bus_err_o is high for exactly one cycle, no mask changes, and bus_rdata_o reads zero.
- R9: With ext_mode_i high, only offsets below 4*EXT_GROUPS (0x40 by default) and the first summary word are legal; every other access is illegal as in R8.
- R10: With ext_mode_i high, inputs of groups EXT_GROUPS and above are ignored: their pending bits stay zero and their outputs stay low.
- R11: While rst_ni is low, all masks and pending bits are cleared, every output is low, and bus_err_o and bus_rdata_o are zero.
- R12: bus_rdata_o is loaded at the clock edge that accepts a read and holds its value while no read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Strap selecting the reduced variant |
| irq_i | input | NUM_GROUPS*8 | Level interrupt sources |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_err_o | output | 1 | One-cycle illegal-access pulse |
| irq_o | output | NUM_GROUPS | Per-group combined interrupt |

## Verification
The bench builds the block with eight groups (64 sources) and an external limit of four, which places the summary word at 0x20 and the reduced window below 0x10. At that size every single source can be walked through every status view, every enable bit can be set and cleared on its own, and each illegal region (status writes, summary writes, addresses past the summary, the narrowed window) is reachable with a handful of accesses, in both strap settings.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned GRP_W    = 8;   // sources per group, one byte lane
  localparam int unsigned LANES    = 4;   // groups per 32-bit word
  localparam int unsigned WORD_W   = 32;

  typedef enum logic [2:0] {
    AK_NONE,
    AK_SET,
    AK_CLR,
    AK_RAW,
    AK_MSK,
    AK_SUM,
    AK_ZERO
  } acc_kind_e;
endpackage

// File: rtl/irq_comb_dec.sv
module irq_comb_dec
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned EXT_GROUPS = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned QW         = 4,
  parameter int unsigned SW         = 1
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [QW-1:0]     quad_o,
  output logic [SW-1:0]     sum_o,
  output logic              bad_o
);
  localparam int unsigned WW   = ADDR_W - 2;
  localparam int unsigned NSUM = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam logic [WW-1:0] SUM_BASE = WW'(NUM_GROUPS);
  localparam logic [WW-1:0] SUM_END  = WW'(NUM_GROUPS + NSUM);
  localparam logic [WW-1:0] EXT_END  = WW'(EXT_GROUPS);

  logic [WW-1:0] word;
  logic          in_grp, in_sum, ext_ok;

  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    in_grp = word < SUM_BASE;
    in_sum = !in_grp && (word < SUM_END);
    ext_ok = (word < EXT_END) || (word == SUM_BASE);
    bad_o  = valid_i && ((ext_i && !ext_ok) || (!in_grp && !in_sum) ||
                         (write_i && (in_sum || word[1])));
  end

  always_comb begin
    kind_o = AK_NONE;
    if (valid_i && !bad_o) begin
      if (write_i)     kind_o = word[0] ? AK_CLR : AK_SET;
      else if (in_sum) kind_o = AK_SUM;
      else begin
        case (word[1:0])
          2'd2:    kind_o = AK_RAW;
          2'd3:    kind_o = AK_MSK;
          default: kind_o = AK_ZERO;
        endcase
      end
    end
  end

  assign quad_o = QW'(word >> 2);
  assign sum_o  = SW'(word - SUM_BASE);
endmodule

// File: rtl/irq_comb_grp.sv
module irq_comb_grp #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         allow_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q, mask_d, pend_q, pend_d;
  logic         irq_q;

  always_comb begin
    mask_d = (mask_q | set_i) & ~clr_i;
    pend_d = allow_i ? src_i : '0;
  end

  // output computed from next state so it moves together with mask/pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |(mask_d & pend_d);
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_comb.sv
module irq_comb
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned EXT_GROUPS = 16,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ext_mode_i,
  input  logic [NUM_GROUPS*GRP_W-1:0]   irq_i,
  input  logic                          bus_valid_i,
  input  logic                          bus_write_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [WORD_W-1:0]             bus_wdata_i,
  output logic [WORD_W-1:0]             bus_rdata_o,
  output logic                          bus_err_o,
  output logic [NUM_GROUPS-1:0]         irq_o
);
  localparam int unsigned NSRC  = NUM_GROUPS * GRP_W;
  localparam int unsigned NQUAD = NUM_GROUPS / LANES;
  localparam int unsigned QW    = (NQUAD > 1) ? $clog2(NQUAD) : 1;
  localparam int unsigned NSUM  = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam int unsigned SW    = (NSUM > 1) ? $clog2(NSUM) : 1;
  localparam int unsigned SUM_W = NSUM * WORD_W;

  acc_kind_e          kind;
  logic [QW-1:0]      quad;
  logic [SW-1:0]      sum_sel;
  logic               bad;
  logic [NSRC-1:0]    mask_all, pend_all, msk_all;
  logic [SUM_W-1:0]   sum_pad;
  logic [WORD_W-1:0]  rd_d, rdata_q;
  logic               err_q;

  irq_comb_dec #(
    .NUM_GROUPS(NUM_GROUPS), .EXT_GROUPS(EXT_GROUPS), .ADDR_W(ADDR_W),
    .QW(QW), .SW(SW)
  ) u_dec (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .ext_i(ext_mode_i),
    .addr_i(bus_addr_i), .kind_o(kind), .quad_o(quad), .sum_o(sum_sel),
    .bad_o(bad)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned QI  = g / LANES;
    localparam int unsigned LI  = g % LANES;
    localparam bit          LOW = (g < EXT_GROUPS);
    logic             hit;
    logic [GRP_W-1:0] set_b, clr_b;

    assign hit   = (quad == QW'(QI));
    assign set_b = (kind == AK_SET && hit) ? bus_wdata_i[GRP_W*LI +: GRP_W] : '0;
    assign clr_b = (kind == AK_CLR && hit) ? bus_wdata_i[GRP_W*LI +: GRP_W] : '0;

    irq_comb_grp #(.W(GRP_W)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (irq_i[GRP_W*g +: GRP_W]),
      .allow_i (LOW | ~ext_mode_i),
      .set_i   (set_b),
      .clr_i   (clr_b),
      .mask_o  (mask_all[GRP_W*g +: GRP_W]),
      .pend_o  (pend_all[GRP_W*g +: GRP_W]),
      .irq_o   (irq_o[g])
    );
  end

  assign msk_all = mask_all & pend_all;

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GROUPS-1:0] = irq_o;
  end

  always_comb begin
    case (kind)
      AK_RAW:  rd_d = pend_all[{quad, 5'b0} +: WORD_W];
      AK_MSK:  rd_d = msk_all[{quad, 5'b0} +: WORD_W];
      AK_SUM:  rd_d = sum_pad[{sum_sel, 5'b0} +: WORD_W];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad;
      if (bus_valid_i && !bus_write_i) rdata_q <= rd_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;
endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk #(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ext_mode_i,
  input logic [NUM_GROUPS*8-1:0]     irq_i,
  input logic                        bus_valid_i,
  input logic                        bus_write_i,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic [31:0]                 bus_rdata_o,
  input logic                        bus_err_o,
  input logic [NUM_GROUPS-1:0]       irq_o,
  input logic [NUM_GROUPS*8-1:0]     mask_all,
  input logic [NUM_GROUPS*8-1:0]     pend_all
);
  localparam logic [ADDR_W-3:0] GRP_WORDS = (ADDR_W-2)'(NUM_GROUPS);

  logic grp_word;
  assign grp_word = bus_addr_i[ADDR_W-1:2] < GRP_WORDS;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_or
    // R1
    grp_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] == |(mask_all[8*g +: 8] & pend_all[8*g +: 8]));
  end

  // R3
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(ext_mode_i)) |-> pend_all == $past(irq_i));

  // R8
  stat_wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i[3]) |=> bus_err_o);

  // R8
  stat_wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i[3]) |=> $stable(mask_all));

  // R6
  en_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && !bus_addr_i[3] && grp_word) |=> bus_rdata_o == 32'd0);

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> $stable(bus_rdata_o));

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && !bus_err_o && bus_rdata_o == 32'd0));
endmodule

bind irq_comb irq_comb_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_mode_i(ext_mode_i), .irq_i(irq_i),
  .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o), .irq_o(irq_o),
  .mask_all(mask_all), .pend_all(pend_all)
);

// File: tb/irq_comb_test.sv
`timescale 1ns/1ps
module irq_comb_test;
  localparam int G  = 8;
  localparam int E  = 4;
  localparam int AW = 12;
  localparam logic [AW-1:0] SUM_A = AW'(4*G);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ext = 1'b0;
  logic [G*8-1:0]  irq_v = '0;
  logic            valid = 1'b0, write = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            err;
  logic [G-1:0]    irq_out;

  logic [7:0]      mask_m [G];
  logic [31:0]     r_data;
  logic            r_err;
  int              n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_comb #(.NUM_GROUPS(G), .EXT_GROUPS(E), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext), .irq_i(irq_v),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err), .irq_o(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = wr; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    r_data = rdata; r_err = err;
  endtask

  task automatic set_en(input int q, input logic [31:0] d);
    acc(1'b1, AW'(16*q), d);
    for (int k = 0; k < 4; k++) mask_m[4*q+k] |= d[8*k +: 8];
  endtask

  task automatic clr_en(input int q, input logic [31:0] d);
    acc(1'b1, AW'(16*q + 4), d);
    for (int k = 0; k < 4; k++) mask_m[4*q+k] &= ~d[8*k +: 8];
  endtask

  task automatic set_irq(input logic [G*8-1:0] v);
    @(negedge clk);
    irq_v = v;
    @(negedge clk);
  endtask

  function automatic logic [G-1:0] exp_out();
    logic [G-1:0] o;
    for (int g = 0; g < G; g++)
      o[g] = (!ext || g < E) && |(mask_m[g] & irq_v[8*g +: 8]);
    return o;
  endfunction

  function automatic logic [31:0] exp_msk(input int q);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mask_m[4*q+k] & irq_v[32*q + 8*k +: 8];
    return w;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int g = 0; g < G; g++) mask_m[g] = '0;
    irq_v = '1;
    repeat (3) @(negedge clk);
    // R11: reset holds everything quiet even with all inputs high
    check("R11 irq_o", 32'(irq_out), 0);
    check("R11 err", 32'(err), 0);
    check("R11 rdata", rdata, 0);
    rst_n = 1'b1;
    irq_v = '0;
    @(negedge clk);
    check("R11 irq_o after release", 32'(irq_out), 0);

    // R4: enable everything
    set_en(0, 32'hFFFF_FFFF);
    set_en(1, 32'hFFFF_FFFF);

    // R1 R6 R7: walk every single source
    for (int n = 0; n < G*8; n++) begin
      set_irq(64'(1) << n);
      check("R1 walk irq_o", 32'(irq_out), 32'(8'(1) << (n/8)));
      acc(1'b0, AW'(16*(n/32) + 8), 0);
      check("R6 walk raw", r_data, 32'(1) << (n%32));
      acc(1'b0, AW'(16*(n/32) + 12), 0);
      check("R6 walk masked", r_data, 32'(1) << (n%32));
      acc(1'b0, SUM_A, 0);
      check("R7 walk summary", r_data, 32'(1) << (n/8));
    end

    // R2: no change before the edge, change at it
    set_irq('0);
    check("R3 drop clears", 32'(irq_out), 0);
    @(negedge clk);
    irq_v = 64'(1) << 13;
    #1 check("R2 before edge", 32'(irq_out), 0);
    @(negedge clk);
    check("R2 after edge", 32'(irq_out), 32'h2);

    // R6: enable words read as zero
    acc(1'b0, AW'(0), 0);
    check("R6 set reads zero", r_data, 0);
    acc(1'b0, AW'(20), 0);
    check("R6 clr reads zero", r_data, 0);

    // R5: clear everything, raw stays, masked drops
    set_irq('1);
    clr_en(0, 32'hFFFF_FFFF);
    clr_en(1, 32'hFFFF_FFFF);
    check("R5 all cleared", 32'(irq_out), 0);
    acc(1'b0, AW'(8), 0);
    check("R6 raw under mask", r_data, 32'hFFFF_FFFF);
    acc(1'b0, AW'(28), 0);
    check("R5 masked cleared", r_data, 0);

    // R4 R5: each enable bit alone
    for (int g = 0; g < G; g++) begin
      for (int b = 0; b < 8; b++) begin
        set_en(g/4, 32'(1) << (8*(g%4) + b));
        check("R4 single enable", 32'(irq_out), 32'(exp_out()));
        acc(1'b0, AW'(16*(g/4) + 12), 0);
        check("R4 single masked", r_data, exp_msk(g/4));
        clr_en(g/4, 32'(1) << (8*(g%4) + b));
        check("R5 single clear", 32'(irq_out), 0);
      end
    end

    // R4: OR behaviour, R5: zero bits keep mask
    set_en(0, 32'h0000_0100);
    set_en(0, 32'h0000_0400);
    acc(1'b0, AW'(12), 0);
    check("R4 set accumulates", r_data, 32'h0000_0500);
    clr_en(0, 32'h0000_0400);
    acc(1'b0, AW'(12), 0);
    check("R5 clear selective", r_data, 32'h0000_0100);

    // R1: pattern of mixed masks and inputs
    set_en(1, 32'h8001_0300);
    set_irq(64'h8000_0200_0000_0000);
    check("R1 mixed pattern", 32'(irq_out), 32'(exp_out()));
    set_irq(64'h0001_0000_0000_0100);
    check("R1 mixed pattern 2", 32'(irq_out), 32'(exp_out()));

    // R3: level, no latching
    set_irq(64'h0000_0000_0000_0100);
    check("R3 level high", 32'(irq_out), 32'h2);
    set_irq('0);
    check("R3 level low", 32'(irq_out), 0);
    acc(1'b0, AW'(8), 0);
    check("R3 raw low", r_data, 0);

    // R8: illegal accesses
    set_irq('1);
    acc(1'b1, AW'(8), 32'hFFFF_FFFF);
    check("R8 raw write err", 32'(r_err), 1);
    @(negedge clk);
    check("R8 err one cycle", 32'(err), 0);
    acc(1'b1, AW'(12), 32'hFFFF_FFFF);
    check("R8 masked write err", 32'(r_err), 1);
    acc(1'b0, AW'(12), 0);
    check("R8 masks unchanged", r_data, exp_msk(0));
    acc(1'b0, AW'(28), 0);
    check("R8 masks unchanged q1", r_data, exp_msk(1));
    acc(1'b1, SUM_A, 32'hFFFF_FFFF);
    check("R8 summary write err", 32'(r_err), 1);
    acc(1'b0, SUM_A, 0);
    check("R7 summary read-only", r_data, 32'(exp_out()));
    check("R7 summary no err", 32'(r_err), 0);
    acc(1'b0, SUM_A + 4, 0);
    check("R8 past summary err", 32'(r_err), 1);
    check("R8 past summary zero", r_data, 0);
    acc(1'b1, AW'(12'h80), 32'hFFFF_FFFF);
    check("R8 far write err", 32'(r_err), 1);

    // R12: read data holds
    acc(1'b0, AW'(8), 0);
    repeat (3) @(negedge clk);
    check("R12 rdata hold", rdata, 32'hFFFF_FFFF);

    // R9 R10: reduced variant
    set_en(0, 32'hFFFF_FFFF);
    set_en(1, 32'hFFFF_FFFF);
    @(negedge clk);
    ext = 1'b1;
    @(negedge clk);
    check("R10 upper groups ignored", 32'(irq_out), 32'h0F);
    acc(1'b0, SUM_A, 0);
    check("R9 summary legal", 32'(r_err), 0);
    check("R10 summary", r_data, 32'h0F);
    acc(1'b0, AW'(8), 0);
    check("R9 low quad legal", 32'(r_err), 0);
    check("R9 low quad raw", r_data, 32'hFFFF_FFFF);
    acc(1'b0, AW'(24), 0);
    check("R9 high quad read err", 32'(r_err), 1);
    check("R9 high quad read zero", r_data, 0);
    acc(1'b1, AW'(20), 32'hFFFF_FFFF);
    check("R9 high quad write err", 32'(r_err), 1);
    acc(1'b0, AW'(12), 0);
    check("R9 low quad masked", r_data, exp_msk(0));
    @(negedge clk);
    ext = 1'b0;
    @(negedge clk);
    check("R9 dropped clear", 32'(irq_out), 32'hFF);

    finish_run();
  end
endmodule